// File: doc/BRIEF.md
# I2C Register Target with Paired Writes

This block is an I2C target that hangs on open-drain SCL and SDA lines and gives a bus master access to a small file of 8-bit registers. Both bus lines are brought into the system clock domain through two-flop synchronisers. START and STOP conditions and SCL edges are detected from the synchronised samples. SDA is never driven high: the single output `sda_oe_o` pulls the line low when it is asserted and releases it otherwise.

A transaction opens with an address byte. With the default parameters this byte is 0x60 for a write and 0x61 for a read. In write mode the bytes that follow alternate between a register address and a data byte, and this goes on until STOP. A single write is one such pair. A longer transaction writes any set of registers in any order, with no auto-increment. To read a register, the master writes a register address, issues a repeated START, sends the read address byte and then clocks out one data byte.

Top module: `i2c_pair_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `DEV_ADDR`, and only such a byte. With the default `DEV_ADDR` of 7'h30, the write byte is 0x60 and the read byte is 0x61. Bit 0 is the direction flag: 0 means write and 1 means read. To acknowledge, the target pulls SDA low for the whole ninth clock.
- R2: An address byte that does not match is not acknowledged. The target then ignores every bit until the next START or STOP. The bytes that follow get no acknowledge and change no register.
- R3: In a single write (address 0x60, register address, data, STOP), each byte is acknowledged. The data byte is stored in the addressed register on the high phase of its acknowledge clock.
- R4: In write mode, the bytes after the address byte are taken alternately as a register address and as data, until STOP. Each data byte goes to the register address just before it. No address auto-increments.
- R5: A read sequence runs as follows: address 0x60, register address, repeated START, address 0x61, one data byte. In that sequence the target returns the register contents, MSB first.
- R6: The target changes `sda_oe_o` only while SCL is low. It only ever pulls SDA low or releases it.
- R7: A register address at or above `NUM_REGS` is acknowledged. A write to it is dropped, and a read from it returns 0x00.
- R8: After the eighth bit of a read byte, the target releases SDA for the master's acknowledge bit. It keeps SDA released until the next START or STOP, whether the master acknowledges or not.
- R9: A repeated START at any point returns the target to address reception. A data byte that the START cut short is not written.
- R10: After reset, all registers hold 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, which samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe_o | output | 1 | When 1, the target pulls SDA low |

## Verification
The hardest case to reach is a repeated START that arrives in the middle of a data byte. At that point the target has already taken in part of the byte and holds a pending register address. The bench sets a register address, clocks four data bits, then raises SDA with SCL low and drops it with SCL high. It then reads back through the same pointer, which shows both that the byte was never written and that address reception resumed. The bench also clocks a second read byte after the master has acknowledged the first. This checks that the target stays off the line past the end of its byte.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADR,
    ST_RX,
    ST_ACK_DAT,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } state_t;
endpackage

// File: rtl/i2c_pair_sync.sv
module i2c_pair_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
  // SDA edge while SCL stays high
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/i2c_pair_regfile.sv
module i2c_pair_regfile #(
  parameter int NUM_REGS = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [i2c_pair_pkg::BYTE_W-1:0] waddr_i,
  input  logic [i2c_pair_pkg::BYTE_W-1:0] wdata_i,
  input  logic [i2c_pair_pkg::BYTE_W-1:0] raddr_i,
  output logic [i2c_pair_pkg::BYTE_W-1:0] rdata_o
);
  import i2c_pair_pkg::*;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
  logic [IDX_W-1:0] ridx, widx;

  assign ridx = raddr_i[IDX_W-1:0];
  assign widx = waddr_i[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && waddr_i == BYTE_W'(g))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < NUM_REGS) ? regs_q[ridx] : '0;

  a_r7_oob_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(waddr_i) >= NUM_REGS) |=> $stable(regs_q));

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(waddr_i) < NUM_REGS) |=> regs_q[$past(widx)] == $past(wdata_i));
endmodule

// File: rtl/i2c_pair_target.sv
module i2c_pair_target #(
  parameter logic [6:0] DEV_ADDR = 7'h30,
  parameter int         NUM_REGS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import i2c_pair_pkg::*;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_pair_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  state_t              state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   shreg_q, ptr_q, rdata;
  logic                expect_addr_q, wr_pend_q, rd_q, sda_oe_q, we;

  // data byte commits on the high phase of its ACK clock
  assign we = (state_q == ST_ACK_DAT) && scl_rise && wr_pend_q;

  i2c_pair_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (ptr_q),
    .wdata_i (shreg_q),
    .raddr_i (ptr_q),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      shreg_q       <= '0;
      ptr_q         <= '0;
      expect_addr_q <= 1'b0;
      wr_pend_q     <= 1'b0;
      rd_q          <= 1'b0;
      sda_oe_q      <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (state_q == ST_ADDR) begin
              if (shreg_q[BYTE_W-1:1] == DEV_ADDR) begin
                sda_oe_q <= 1'b1;
                rd_q     <= shreg_q[0];
                if (!shreg_q[0]) expect_addr_q <= 1'b1;
                state_q  <= ST_ACK_ADR;
              end else begin
                state_q  <= ST_WAIT;
              end
            end else begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_ACK_DAT;
              if (expect_addr_q) begin
                ptr_q     <= shreg_q;
                wr_pend_q <= 1'b0;
              end else begin
                wr_pend_q <= 1'b1;
              end
              expect_addr_q <= ~expect_addr_q;
            end
          end
        end
        ST_ACK_ADR: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rd_q) begin
              shreg_q  <= rdata;
              sda_oe_q <= ~rdata[BYTE_W-1];
              state_q  <= ST_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RX;
            end
          end
        end
        ST_ACK_DAT: begin
          if (scl_fall) begin
            sda_oe_q  <= 1'b0;
            wr_pend_q <= 1'b0;
            cnt_q     <= '0;
            state_q   <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_MACK;
            end else begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: if (scl_rise) state_q <= ST_WAIT;
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  a_r6_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  a_r2_silent_when_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sda_oe_o);

  a_r9_start_to_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0));

  a_r9_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !sda_oe_o));

  a_r4_bit_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_BIT);

  a_r8_release_for_master_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK) |-> !sda_oe_o);
endmodule

// File: tb/i2c_pair_target_test.sv
module i2c_pair_target_test;
  localparam int HP = 20;

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_line = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   checks = 0;
  int   fails  = 0;
  int   r6_viol = 0;
  logic oe_prev = 1'b0;

  item_t      exp_q[$];
  logic [7:0] act_q[$];

  always #5 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_pair_target uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_line),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t      e;
      logic [7:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      check(e.req, a, e.val);
    end
  end

  // R6: line owner must not move SDA while SCL is high
  always @(posedge clk) begin
    if (rst_n && scl_line && sda_oe !== oe_prev) r6_viol++;
    oe_prev <= sda_oe;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start();
    m_low = 1'b0;
    wait_cyc(HP);
    scl_line = 1'b1;
    wait_cyc(HP);
    m_low = 1'b1;
    wait_cyc(HP);
    scl_line = 1'b0;
    wait_cyc(HP / 2);
  endtask

  task automatic m_stop();
    m_low = 1'b1;
    wait_cyc(HP / 2);
    scl_line = 1'b1;
    wait_cyc(HP);
    m_low = 1'b0;
    wait_cyc(HP);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b;
    wait_cyc(HP / 2);
    scl_line = 1'b1;
    wait_cyc(HP);
    scl_line = 1'b0;
    wait_cyc(HP / 2);
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0;
    wait_cyc(HP / 2);
    scl_line = 1'b1;
    wait_cyc(HP / 2);
    b = sda_line;
    wait_cyc(HP / 2);
    scl_line = 1'b0;
    wait_cyc(HP / 2);
  endtask

  // driver: push expected ack (0) or nack (1), then shift the byte
  task automatic tx(input logic [7:0] v, input logic nack, input string req);
    logic a;
    exp_q.push_back('{req, {7'b0, nack}});
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    act_q.push_back({7'b0, a});
  endtask

  task automatic rx(input logic m_nack, input logic [7:0] expv, input string req);
    logic [7:0] d;
    logic       b;
    exp_q.push_back('{req, expv});
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    act_q.push_back(d);
    send_bit(m_nack);
  endtask

  task automatic read_reg(input logic [7:0] ra, input logic [7:0] expv, input string req);
    m_start();
    tx(8'h60, 1'b0, "R1");
    tx(ra, 1'b0, "R5");
    m_start();
    tx(8'h61, 1'b0, "R1");
    rx(1'b1, expv, req);
    m_stop();
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R10 sda released after reset", {7'b0, sda_oe}, 8'h00);
    read_reg(8'h02, 8'h00, "R10 reset value");

    // R3 single write
    m_start();
    tx(8'h60, 1'b0, "R1");
    tx(8'h02, 1'b0, "R3");
    tx(8'hA5, 1'b0, "R3");
    m_stop();
    read_reg(8'h02, 8'hA5, "R3 stored data");

    // R4 paired multi-byte write
    m_start();
    tx(8'h60, 1'b0, "R1");
    tx(8'h05, 1'b0, "R4");
    tx(8'h3C, 1'b0, "R4");
    tx(8'h01, 1'b0, "R4");
    tx(8'h81, 1'b0, "R4");
    tx(8'h07, 1'b0, "R4");
    tx(8'hFF, 1'b0, "R4");
    m_stop();
    read_reg(8'h05, 8'h3C, "R4 pair 1");
    read_reg(8'h01, 8'h81, "R4 pair 2");
    read_reg(8'h07, 8'hFF, "R4 pair 3");
    read_reg(8'h06, 8'h00, "R4 no auto-increment");

    // R2 address mismatch
    m_start();
    tx(8'h62, 1'b1, "R2 no ack on mismatch");
    tx(8'h02, 1'b1, "R2 ignored byte");
    tx(8'h11, 1'b1, "R2 ignored byte");
    m_stop();
    read_reg(8'h02, 8'hA5, "R2 register untouched");

    // R7 unimplemented register
    m_start();
    tx(8'h60, 1'b0, "R7");
    tx(8'h20, 1'b0, "R7 ack on unimplemented addr");
    tx(8'h77, 1'b0, "R7 ack on dropped data");
    m_stop();
    read_reg(8'h20, 8'h00, "R7 unimplemented reads zero");

    // R8 master acks, extra byte must see a released line
    m_start();
    tx(8'h60, 1'b0, "R1");
    tx(8'h05, 1'b0, "R5");
    m_start();
    tx(8'h61, 1'b0, "R1");
    rx(1'b0, 8'h3C, "R5 read data");
    rx(1'b1, 8'hFF, "R8 line released after read byte");
    m_stop();

    // R9 repeated start in the middle of a data byte
    m_start();
    tx(8'h60, 1'b0, "R1");
    tx(8'h01, 1'b0, "R9");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    m_start();
    tx(8'h61, 1'b0, "R9 address after repeated start");
    rx(1'b1, 8'h81, "R9 cut byte not written");
    m_stop();

    wait_cyc(4);
    check("R6 sda moves only with scl low", r6_viol[7:0], 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule